// File: doc/BRIEF.md
# Status Byte and Service Request Generator

This block gathers summary conditions from the status reporting sources below it into one 8-bit status byte. A host reads that byte by query or by serial poll. Three of its bits are reductions of event and enable vector pairs: the questionable group, the operation group, and the event status group. Two more bits follow single condition inputs: the error queue holds an entry, and a message is waiting in the output buffer. The block computes these bits itself.

A host-writable enable mask selects which status bits may raise a service request. Bit 6 of the status byte is not an input condition. It is the master summary: it is set whenever any other status bit is set together with its mask bit. The mask position for bit 6 has no meaning, so it is stored as zero.

A service request is raised on a 0-to-1 transition of an enabled status bit. A level that is already high does not raise one. The request line stays high until a serial-poll acknowledge pulse clears it.

Top module: `stb_srq_unit`

## Requirements
- R1: Status byte bits 1 and 0 always read as 0.
- R2: Status byte bit 2 equals `err_q_nonempty` and bit 4 equals `msg_ready`, in the same cycle, with no register delay.
- R3: Status byte bit 3 is 1 exactly when some bit position has both `ques_evt` and `ques_en` set.
- R4: Status byte bit 7 is 1 exactly when some bit position has both `oper_evt` and `oper_en` set.
- R5: Status byte bit 5 is 1 exactly when some bit position has both `esr_evt` and `esr_en` set.
- R6: Status byte bit 6 is 1 exactly when some status bit other than bit 6 is set and its bit in the stored enable mask is also set.
- R7: A cycle with `mask_wr_en` high stores `mask_wr_data`, with bit 6 forced to 0. The stored value appears on `mask_rd` from the next cycle and is held until the next write.
- R8: When a status bit other than bit 6 is 1 in this cycle, was 0 in the previous cycle, and its mask bit is 1, `srq` is 1 from the next cycle.
- R9: No request is raised by a rising status bit whose mask bit is 0. No request is raised by enabling the mask for a status bit that is already 1. No request is raised by writing mask bit 6.
- R10: Once set, `srq` stays 1 until a cycle with `poll_ack` high, after which it is 0. If an enabled rising edge occurs in the same cycle as `poll_ack`, `srq` stays 1.
- R11: Synchronous active-high `rst` clears the enable mask, the stored previous status byte and `srq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_q_nonempty | input | 1 | Error queue holds at least one entry |
| msg_ready | input | 1 | Readable message waiting in output buffer |
| ques_evt | input | QUES_W | Questionable group event bits |
| ques_en | input | QUES_W | Questionable group enable bits |
| oper_evt | input | OPER_W | Operation group event bits |
| oper_en | input | OPER_W | Operation group enable bits |
| esr_evt | input | ESR_W | Event status register bits |
| esr_en | input | ESR_W | Event status enable bits |
| mask_wr_en | input | 1 | Write strobe for the request enable mask |
| mask_wr_data | input | 8 | Value to write into the enable mask |
| poll_ack | input | 1 | Serial-poll acknowledge pulse, clears the request |
| status_byte | output | 8 | Current status byte |
| mask_rd | output | 8 | Stored enable mask (bit 6 always 0) |
| srq | output | 1 | Service request line |

## Verification
The request assertions compare the status byte with its value one cycle earlier. They therefore assume that the condition and vector inputs are settled once per clock and that `poll_ack` is a level sampled at the edge. The stimulus changes every input only at the falling clock edge. The acknowledge-clear property also assumes the status byte has not moved across the acknowledge cycle. The stimulus includes such quiet acknowledge cycles, and it also applies an acknowledge together with a fresh enabled edge. A reset is applied while a request is pending, and the request-edge checks are not relied on in the first cycle after that reset.

// File: rtl/stb_pkg.sv
package stb_pkg;

    localparam int STB_W     = 8;
    localparam int BIT_ERRQ  = 2;
    localparam int BIT_QUES  = 3;
    localparam int BIT_MAV   = 4;
    localparam int BIT_ESUM  = 5;
    localparam int BIT_MSS   = 6;
    localparam int BIT_OPER  = 7;

    localparam logic [STB_W-1:0] MSS_ONEHOT = STB_W'(1) << BIT_MSS;
    localparam logic [STB_W-1:0] MASK_KEEP  = ~MSS_ONEHOT;

    typedef struct packed {
        logic [STB_W-1:0] mask;
    } mask_state_t;

    typedef struct packed {
        logic [STB_W-1:0] prev;
        logic             req;
    } srq_state_t;

endpackage

// File: rtl/masked_summary.sv
module masked_summary #(
    parameter int W     = 16,
    parameter int GROUP = 4
) (
    input  logic [W-1:0] evt_i,
    input  logic [W-1:0] en_i,
    output logic         any_o
);
    localparam int NGRP = (W + GROUP - 1) / GROUP;
    localparam int PADW = NGRP * GROUP;

    logic [PADW-1:0] hit;
    logic [NGRP-1:0] grp_any;

    always_comb begin
        hit        = '0;
        hit[W-1:0] = evt_i & en_i;
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign grp_any[g] = |hit[g*GROUP +: GROUP];
    end

    assign any_o = |grp_any;
endmodule

// File: rtl/status_assembler.sv
module status_assembler
    import stb_pkg::*;
(
    input  logic             errq_i,
    input  logic             mav_i,
    input  logic             ques_sum_i,
    input  logic             esr_sum_i,
    input  logic             oper_sum_i,
    input  logic [STB_W-1:0] mask_i,
    output logic [STB_W-1:0] stb_o
);
    logic [STB_W-1:0] base;

    for (genvar b = 0; b < STB_W; b++) begin : g_bit
        if (b == BIT_ERRQ) begin : g_errq
            assign base[b] = errq_i;
        end else if (b == BIT_QUES) begin : g_ques
            assign base[b] = ques_sum_i;
        end else if (b == BIT_MAV) begin : g_mav
            assign base[b] = mav_i;
        end else if (b == BIT_ESUM) begin : g_esum
            assign base[b] = esr_sum_i;
        end else if (b == BIT_OPER) begin : g_oper
            assign base[b] = oper_sum_i;
        end else begin : g_zero
            assign base[b] = 1'b0;
        end
    end

    always_comb begin
        stb_o          = base;
        stb_o[BIT_MSS] = |(base & mask_i & MASK_KEEP);
    end
endmodule

// File: rtl/srq_edge_ctrl.sv
module srq_edge_ctrl
    import stb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [STB_W-1:0] stb_i,
    input  logic [STB_W-1:0] en_i,
    input  logic             ack_i,
    output logic             srq_o
);
    srq_state_t       st_d, st_q;
    logic [STB_W-1:0] rise_d;

    always_comb begin
        st_d   = st_q;
        rise_d = stb_i & ~st_q.prev & en_i & MASK_KEEP;
        st_d.prev = stb_i;
        if (|rise_d) begin
            st_d.req = 1'b1;
        end else if (ack_i) begin
            st_d.req = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign srq_o = st_q.req;

    p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (ack_i && (|rise_d)) |=> srq_o);
endmodule

// File: rtl/stb_srq_unit.sv
module stb_srq_unit
    import stb_pkg::*;
#(
    parameter int QUES_W = 16,
    parameter int OPER_W = 16,
    parameter int ESR_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              err_q_nonempty,
    input  logic              msg_ready,
    input  logic [QUES_W-1:0] ques_evt,
    input  logic [QUES_W-1:0] ques_en,
    input  logic [OPER_W-1:0] oper_evt,
    input  logic [OPER_W-1:0] oper_en,
    input  logic [ESR_W-1:0]  esr_evt,
    input  logic [ESR_W-1:0]  esr_en,
    input  logic              mask_wr_en,
    input  logic [7:0]        mask_wr_data,
    input  logic              poll_ack,
    output logic [7:0]        status_byte,
    output logic [7:0]        mask_rd,
    output logic              srq
);
    mask_state_t      m_d, m_q;
    logic             ques_sum, oper_sum, esr_sum;
    logic [STB_W-1:0] stb_w;

    always_comb begin
        m_d = m_q;
        if (mask_wr_en) begin
            m_d.mask = mask_wr_data & MASK_KEEP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    masked_summary #(.W(QUES_W)) u_ques (
        .evt_i(ques_evt), .en_i(ques_en), .any_o(ques_sum));
    masked_summary #(.W(OPER_W)) u_oper (
        .evt_i(oper_evt), .en_i(oper_en), .any_o(oper_sum));
    masked_summary #(.W(ESR_W))  u_esr  (
        .evt_i(esr_evt),  .en_i(esr_en),  .any_o(esr_sum));

    status_assembler u_asm (
        .errq_i     (err_q_nonempty),
        .mav_i      (msg_ready),
        .ques_sum_i (ques_sum),
        .esr_sum_i  (esr_sum),
        .oper_sum_i (oper_sum),
        .mask_i     (m_q.mask),
        .stb_o      (stb_w)
    );

    srq_edge_ctrl u_srq (
        .clk   (clk),
        .rst   (rst),
        .stb_i (stb_w),
        .en_i  (m_q.mask),
        .ack_i (poll_ack),
        .srq_o (srq)
    );

    assign status_byte = stb_w;
    assign mask_rd     = m_q.mask;

    p_mask_write_r7: assert property (@(posedge clk) disable iff (rst)
        mask_wr_en |=> (mask_rd == ($past(mask_wr_data) & 8'hBF)));

    p_mask_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !mask_wr_en |=> $stable(mask_rd));

    p_rise_sets_r8: assert property (@(posedge clk) disable iff (rst)
        (|(status_byte & ~$past(status_byte) & mask_rd & 8'hBF)) |=> srq);

    p_no_spurious_r9: assert property (@(posedge clk) disable iff (rst)
        (!srq && !(|(status_byte & ~$past(status_byte) & mask_rd & 8'hBF))) |=> !srq);

    p_hold_until_ack_r10: assert property (@(posedge clk) disable iff (rst)
        (srq && !poll_ack) |=> srq);

    p_ack_clears_r10: assert property (@(posedge clk) disable iff (rst)
        (poll_ack && !$past(rst) && $stable(status_byte)) |=> !srq);

    p_reset_state_r11: assert property (@(posedge clk)
        rst |=> (!srq && mask_rd == 8'h00));

    p_low_bits_r1: assert property (@(posedge clk) disable iff (rst)
        status_byte[1:0] == 2'b00);
endmodule

// File: tb/stb_srq_unit_tb_top.sv
module stb_srq_unit_tb_top;
    localparam int QW = 16;
    localparam int OW = 16;
    localparam int EW = 8;
    localparam time CLK_P = 10ns;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          err_q_nonempty = 1'b0, msg_ready = 1'b0;
    logic [QW-1:0] ques_evt = '0, ques_en = '0;
    logic [OW-1:0] oper_evt = '0, oper_en = '0;
    logic [EW-1:0] esr_evt = '0, esr_en = '0;
    logic          mask_wr_en = 1'b0;
    logic [7:0]    mask_wr_data = '0;
    logic          poll_ack = 1'b0;
    logic [7:0]    status_byte, mask_rd;
    logic          srq;

    always #(CLK_P/2) clk = ~clk;

    stb_srq_unit #(.QUES_W(QW), .OPER_W(OW), .ESR_W(EW)) dut_i (
        .clk(clk), .rst(rst), .err_q_nonempty(err_q_nonempty), .msg_ready(msg_ready),
        .ques_evt(ques_evt), .ques_en(ques_en), .oper_evt(oper_evt), .oper_en(oper_en),
        .esr_evt(esr_evt), .esr_en(esr_en), .mask_wr_en(mask_wr_en),
        .mask_wr_data(mask_wr_data), .poll_ack(poll_ack), .status_byte(status_byte),
        .mask_rd(mask_rd), .srq(srq));

    typedef struct {
        int         sel;
        logic [7:0] bits;
        logic [7:0] exp;
        string      req;
    } item_t;

    item_t q[$];
    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    logic [7:0] m_mask = '0, m_prev = '0;
    logic       m_srq = 1'b0;
    string      srq_tag = "R11";

    task automatic push(int sel, logic [7:0] bits, logic [7:0] exp, string req);
        item_t it;
        it.sel = sel; it.bits = bits; it.exp = exp; it.req = req;
        q.push_back(it);
    endtask

    // driver: called at a falling edge with the inputs already set
    task automatic step();
        logic [7:0] stb, rise;
        stb = '0;
        stb[2] = err_q_nonempty;
        stb[3] = |(ques_evt & ques_en);
        stb[4] = msg_ready;
        stb[5] = |(esr_evt & esr_en);
        stb[7] = |(oper_evt & oper_en);
        stb[6] = |(stb & m_mask & 8'hBF);
        push(0, 8'h03, 8'h00, "R1");
        push(0, 8'h14, stb, "R2");
        push(0, 8'h08, stb, "R3");
        push(0, 8'h80, stb, "R4");
        push(0, 8'h20, stb, "R5");
        push(0, 8'h40, stb, "R6");
        push(1, 8'hFF, m_mask, "R7");
        push(2, 8'h01, {7'b0, m_srq}, srq_tag);
        if (rst) begin
            m_mask = '0; m_prev = '0; m_srq = 1'b0;
        end else begin
            rise = stb & ~m_prev & m_mask & 8'hBF;
            if (|rise) m_srq = 1'b1;
            else if (poll_ack) m_srq = 1'b0;
            m_prev = stb;
            if (mask_wr_en) m_mask = mask_wr_data & 8'hBF;
        end
        @(negedge clk);
    endtask

    // monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                item_t it;
                logic [7:0] got;
                it = q.pop_front();
                got = (it.sel == 0) ? status_byte : (it.sel == 1) ? mask_rd : {7'b0, srq};
                n_vec++;
                if ((got & it.bits) !== (it.exp & it.bits)) begin
                    n_bad++;
                    $display("FAIL %s sel=%0d actual=%02h expected=%02h", it.req, it.sel,
                             got & it.bits, it.exp & it.bits);
                end
            end
        end
    end

    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic write_mask(logic [7:0] v);
        mask_wr_en = 1'b1; mask_wr_data = v;
        step();
        mask_wr_en = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        srq_tag = "R11";
        rst = 1'b1; step(); step();
        rst = 1'b0; step();

        // R3 R4 R5: vector summaries, disjoint then overlapping positions
        srq_tag = "R9";
        ques_evt = 16'h0F00; ques_en = 16'h00F0; step();
        ques_en = 16'h0100; step();
        oper_evt = 16'h8000; oper_en = 16'h7FFF; step();
        oper_en = 16'h8001; step();
        esr_evt = 8'h21; esr_en = 8'h02; step();
        esr_en = 8'h01; step();
        // R2: single conditions
        err_q_nonempty = 1'b1; msg_ready = 1'b1; step();
        err_q_nonempty = 1'b0; msg_ready = 1'b0; step();
        ques_evt = '0; oper_evt = '0; esr_evt = '0; step();

        // R7: mask write forces bit 6 to 0; R9: mask bit 6 alone raises nothing
        write_mask(8'h40); step();
        write_mask(8'hFF); step(); step();

        // R8: enabled error bit rises
        srq_tag = "R8";
        err_q_nonempty = 1'b1; step(); step();
        // R10: holds without ack, clears on ack
        srq_tag = "R10";
        step(); step();
        poll_ack = 1'b1; step();
        poll_ack = 1'b0; step(); step();

        // R9: rising bit with mask bit clear
        srq_tag = "R9";
        write_mask(8'h04); step();
        msg_ready = 1'b1; step(); step();
        // R9: enabling an already-set bit raises no request (R6 bit 6 follows)
        write_mask(8'h14); step(); step();

        // R8: operation summary rise through the vector path
        srq_tag = "R8";
        write_mask(8'h80);
        oper_evt = 16'h0002; oper_en = 16'h0002; step(); step();

        // R10: ack together with a new enabled rise keeps the request
        srq_tag = "R10";
        poll_ack = 1'b1; step();
        poll_ack = 1'b0; step();
        poll_ack = 1'b1; oper_evt = '0; step();
        poll_ack = 1'b1; oper_evt = 16'h0002; step();
        poll_ack = 1'b0; step(); step();

        // R11: reset while request pending
        srq_tag = "R11";
        rst = 1'b1; step();
        rst = 1'b0; step(); step();

        step();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule